// File: doc/BRIEF.md
# Receive Character Filter with Receiver Disable

This block sits between a UART receive deserializer and the receive FIFO. Each time the deserializer presents a completed character, the filter decides three things. It decides whether the character is written into the FIFO. It decides whether the character is an in-band flow control character (resume or pause). It decides whether the character matches a programmed special value. The filter also holds the receiver-disable state and a sticky special-character-detected flag. Software clears that flag by reading the status register. The flag tells software whether a shared interrupt came from a special character or from a pause (XOFF) character.

When the receiver is disabled, the deserializer keeps framing characters and flow control characters still take effect. Nothing is stored, and special-character matching is suppressed. A new value on the disable control is taken into an effective copy only while no character is in progress. A character that is already being received therefore finishes under the setting it started with.

All outputs are registered. They respond one clock after the cycle in which `char_valid` is sampled.

Top module: `rx_char_filter`

## Requirements
- R1: While the effective disable is 0, a cycle with `char_valid` high gives `fifo_wr` high in the next cycle, with `fifo_wdata` equal to the sampled `char_data`. With `char_valid` low, `fifo_wr` is low in the next cycle.
- R2: While the effective disable is 1, no character produces `fifo_wr`.
- R3: A valid character equal to `xoff_code` pulses `xoff_evt` in the next cycle. Otherwise, a valid character equal to `xon_code` pulses `xon_evt`. XOFF wins when both codes are equal. Both pulses fire whatever the disable state is.
- R4: A valid character equal to `spec_code` while the effective disable is 0 sets `spec_flag` in the next cycle. It is still written to the FIFO. While disabled, such a character leaves `spec_flag` unchanged.
- R5: `spec_flag` clears in the cycle after `status_rd`. If a set condition arrives in the same cycle as the read, the flag stays set.
- R6: The effective disable loads `rx_dis_cfg` only in cycles where `rx_busy` is low. While `rx_busy` is high it keeps its previous value.
- R7: `irq_cause` pulses for one cycle, one cycle after either an accepted special-character match or an XOFF character.
- R8: Synchronous reset clears all outputs and sets the effective disable to 0 (enabled).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_valid | input | 1 | Completed-character strobe from the deserializer |
| char_data | input | CHAR_W | Completed character |
| rx_busy | input | 1 | High from start bit to stop bit of a character in progress |
| xon_code | input | CHAR_W | Programmed resume character |
| xoff_code | input | CHAR_W | Programmed pause character |
| spec_code | input | CHAR_W | Programmed special character |
| rx_dis_cfg | input | 1 | Receiver-disable bit from the control register |
| status_rd | input | 1 | Status-register read strobe |
| fifo_wr | output | 1 | Receive FIFO write strobe |
| fifo_wdata | output | CHAR_W | Receive FIFO write data |
| xon_evt | output | 1 | Resume character received |
| xoff_evt | output | 1 | Pause character received |
| spec_flag | output | 1 | Sticky special-character-detected flag |
| irq_cause | output | 1 | Interrupt-cause pulse (special match or pause) |

## Verification
The hardest case to reach is a disable change that arrives while a character is in progress. The FIFO writes must follow the old setting until `rx_busy` falls, and only then switch. A directed sequence toggles `rx_dis_cfg` with `rx_busy` held high across several valid characters, then drops `rx_busy`. A second directed case presents a special character in the same cycle as a status read, to show that the set wins. The random phase draws characters mostly from the three programmed codes and includes an equal XON/XOFF configuration, so the priority and suppression paths are hit often.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int CHAR_W_DEF = 8;

    typedef struct packed {
        logic hit_xon;
        logic hit_xoff;
        logic hit_spec;
    } rxf_match_t;

    function automatic rxf_match_t rxf_classify(
        input logic [CHAR_W_DEF-1:0] ch,
        input logic [CHAR_W_DEF-1:0] xon_c,
        input logic [CHAR_W_DEF-1:0] xoff_c,
        input logic [CHAR_W_DEF-1:0] spec_c
    );
        rxf_match_t m;
        m.hit_xoff = (ch == xoff_c);
        m.hit_xon  = (ch == xon_c) && !m.hit_xoff;
        m.hit_spec = (ch == spec_c);
        return m;
    endfunction
endpackage

// File: rtl/rxf_classify.sv
module rxf_classify
    import rxf_pkg::*;
#(
    parameter int CHAR_W = CHAR_W_DEF
) (
    input  logic [CHAR_W-1:0] ch,
    input  logic [CHAR_W-1:0] xon_c,
    input  logic [CHAR_W-1:0] xoff_c,
    input  logic [CHAR_W-1:0] spec_c,
    output rxf_match_t        match
);
    localparam int PADW = CHAR_W_DEF - CHAR_W;

    generate
        if (PADW > 0) begin : g_pad
            assign match = rxf_classify({{PADW{1'b0}}, ch}, {{PADW{1'b0}}, xon_c},
                                        {{PADW{1'b0}}, xoff_c}, {{PADW{1'b0}}, spec_c});
        end else begin : g_direct
            always_comb begin
                match.hit_xoff = (ch == xoff_c);
                match.hit_xon  = (ch == xon_c) && !(ch == xoff_c);
                match.hit_spec = (ch == spec_c);
            end
        end
    endgenerate

    always_comb begin
        assert (!(match.hit_xon && match.hit_xoff))
            else $error("AST_XON_XOFF_EXCL"); // R3
    end
endmodule

// File: rtl/rxf_dis_latch.sv
module rxf_dis_latch (
    input  logic clk,
    input  logic rst,
    input  logic rx_busy,
    input  logic dis_cfg,
    output logic dis_eff
);
    always_ff @(posedge clk) begin
        if (rst)
            dis_eff <= 1'b0;
        else if (!rx_busy)
            dis_eff <= dis_cfg;
    end

    AST_DIS_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
        rx_busy |=> $stable(dis_eff)); // R6
    AST_DIS_LOAD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rx_busy |=> (dis_eff == $past(dis_cfg))); // R6
endmodule

// File: rtl/rxf_spec_flag.sv
module rxf_spec_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic rd_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (rd_i)
            flag_o <= 1'b0;
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o); // R4
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !set_i) |=> !flag_o); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!rd_i && flag_o) |=> flag_o); // R5
endmodule

// File: rtl/rx_char_filter.sv
module rx_char_filter
    import rxf_pkg::*;
#(
    parameter int CHAR_W = CHAR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              char_valid,
    input  logic [CHAR_W-1:0] char_data,
    input  logic              rx_busy,
    input  logic [CHAR_W-1:0] xon_code,
    input  logic [CHAR_W-1:0] xoff_code,
    input  logic [CHAR_W-1:0] spec_code,
    input  logic              rx_dis_cfg,
    input  logic              status_rd,
    output logic              fifo_wr,
    output logic [CHAR_W-1:0] fifo_wdata,
    output logic              xon_evt,
    output logic              xoff_evt,
    output logic              spec_flag,
    output logic              irq_cause
);
    rxf_match_t match;
    logic       dis_eff;
    logic       spec_accept;

    rxf_classify #(.CHAR_W(CHAR_W)) classify_i (
        .ch     (char_data),
        .xon_c  (xon_code),
        .xoff_c (xoff_code),
        .spec_c (spec_code),
        .match  (match)
    );

    rxf_dis_latch dis_i (
        .clk     (clk),
        .rst     (rst),
        .rx_busy (rx_busy),
        .dis_cfg (rx_dis_cfg),
        .dis_eff (dis_eff)
    );

    assign spec_accept = char_valid && !dis_eff && match.hit_spec;

    rxf_spec_flag flag_i (
        .clk    (clk),
        .rst    (rst),
        .set_i  (spec_accept),
        .rd_i   (status_rd),
        .flag_o (spec_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_wr    <= 1'b0;
            fifo_wdata <= '0;
            xon_evt    <= 1'b0;
            xoff_evt   <= 1'b0;
            irq_cause  <= 1'b0;
        end else begin
            fifo_wr    <= char_valid && !dis_eff;
            if (char_valid && !dis_eff)
                fifo_wdata <= char_data;
            xon_evt    <= char_valid && match.hit_xon;
            xoff_evt   <= char_valid && match.hit_xoff;
            irq_cause  <= spec_accept || (char_valid && match.hit_xoff);
        end
    end

    AST_WR_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        !char_valid |=> !fifo_wr); // R1
    AST_NO_WR_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (char_valid && dis_eff) |=> !fifo_wr); // R2
    AST_EVT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({xon_evt, xoff_evt})); // R3
    AST_XOFF_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        xoff_evt |-> irq_cause); // R7
endmodule

// File: tb/rx_char_filter_tb_top.sv
module rx_char_filter_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         char_valid, rx_busy, rx_dis_cfg, status_rd;
    logic [W-1:0] char_data, xon_code, xoff_code, spec_code;
    logic         fifo_wr, xon_evt, xoff_evt, spec_flag, irq_cause;
    logic [W-1:0] fifo_wdata;

    int n_vec  = 0;
    int n_fail = 0;

    // bench model state
    logic         m_dis, m_flag;
    logic         e_wr, e_xon, e_xoff, e_irq;
    logic [W-1:0] e_data;

    always #10 clk = ~clk; // 50 MHz

    rx_char_filter #(.CHAR_W(W)) dut_i (
        .clk(clk), .rst(rst), .char_valid(char_valid), .char_data(char_data),
        .rx_busy(rx_busy), .xon_code(xon_code), .xoff_code(xoff_code),
        .spec_code(spec_code), .rx_dis_cfg(rx_dis_cfg), .status_rd(status_rd),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .xon_evt(xon_evt),
        .xoff_evt(xoff_evt), .spec_flag(spec_flag), .irq_cause(irq_cause)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // drive one cycle on the negedge, predict, then check after the posedge
    task automatic step(input logic v, input logic [W-1:0] d, input logic busy,
                        input logic dis, input logic rd);
        logic xoff_h, xon_h, spec_acc;
        char_valid = v; char_data = d; rx_busy = busy; rx_dis_cfg = dis; status_rd = rd;
        xoff_h   = v && (d == xoff_code);
        xon_h    = v && (d == xon_code) && !xoff_h;
        spec_acc = v && !m_dis && (d == spec_code);
        e_wr  = v && !m_dis;
        if (e_wr) e_data = d;
        e_xon = xon_h;
        e_xoff = xoff_h;
        e_irq = spec_acc || xoff_h;
        if (spec_acc) m_flag = 1'b1;
        else if (rd) m_flag = 1'b0;
        if (!busy) m_dis = dis;
        @(posedge clk);
        @(negedge clk);
        chk("R1/R2 fifo_wr", fifo_wr, e_wr);
        if (e_wr) chk("R1 fifo_wdata", fifo_wdata, e_data);
        chk("R3 xon_evt", xon_evt, e_xon);
        chk("R3 xoff_evt", xoff_evt, e_xoff);
        chk("R4/R5 spec_flag", spec_flag, m_flag);
        chk("R7 irq_cause", irq_cause, e_irq);
    endtask

    function automatic logic [W-1:0] pick_char(input int sel);
        case (sel % 5)
            0: return xon_code;
            1: return xoff_code;
            2: return spec_code;
            default: return W'($urandom);
        endcase
    endfunction

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        xon_code = 8'h11; xoff_code = 8'h13; spec_code = 8'h7E;
        char_valid = 0; char_data = 0; rx_busy = 0; rx_dis_cfg = 0; status_rd = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 fifo_wr", fifo_wr, 0);
        chk("R8 xon_evt", xon_evt, 0);
        chk("R8 xoff_evt", xoff_evt, 0);
        chk("R8 spec_flag", spec_flag, 0);
        chk("R8 irq_cause", irq_cause, 0);
        rst = 0;
        m_dis = 0; m_flag = 0; e_data = 0;
        // R8: effective disable starts enabled even with cfg=1 held busy
        step(1, 8'h41, 1, 1, 0);
        chk("R8 enabled after reset", fifo_wr, 1);

        // R1 plain store
        step(1, 8'hA5, 0, 0, 0);
        step(0, 8'h00, 0, 0, 0);
        // R4 special stored and flagged
        step(1, spec_code, 0, 0, 0);
        chk("R4 special stored", fifo_wdata, spec_code);
        // R5 read clears
        step(0, 8'h00, 0, 0, 1);
        chk("R5 flag cleared", spec_flag, 0);
        // R5 set and read in same cycle: set wins
        step(1, spec_code, 0, 0, 1);
        chk("R5 set wins over read", spec_flag, 1);
        step(0, 8'h00, 0, 0, 1);

        // R6: request disable while busy -> still storing
        step(0, 8'h00, 1, 1, 0);
        step(1, 8'h22, 1, 1, 0);
        chk("R6 still enabled while busy", fifo_wr, 1);
        step(1, 8'h23, 0, 1, 0); // latches disable now
        step(1, 8'h24, 1, 1, 0);
        chk("R2 disabled, no write", fifo_wr, 0);
        // R4 special ignored when disabled; R3 flow control still works
        step(1, spec_code, 1, 1, 0);
        chk("R4 special ignored when disabled", spec_flag, 0);
        step(1, xoff_code, 1, 1, 0);
        chk("R3 xoff while disabled", xoff_evt, 1);
        step(1, xon_code, 1, 0, 0);
        chk("R3 xon while disabled", xon_evt, 1);
        step(1, 8'h55, 0, 0, 0); // re-enable takes effect after this
        step(1, 8'h56, 0, 0, 0);
        chk("R6 re-enabled", fifo_wr, 1);

        // R3 priority with equal codes
        xon_code = 8'h13;
        step(1, 8'h13, 0, 0, 0);
        chk("R3 xoff priority", {xon_evt, xoff_evt}, 2'b01);
        xon_code = 8'h11;

        // random phase
        for (int i = 0; i < 3000; i++) begin
            if (i == 1500) xon_code = xoff_code;
            step(($urandom % 3) != 0, pick_char($urandom), ($urandom % 4) != 0,
                 ($urandom % 8) == 0 ? ~rx_dis_cfg : rx_dis_cfg, ($urandom % 6) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule